// File: doc/BRIEF.md
# Header-Checked Packet Receiver with Resynchronisation

This block turns an unframed byte stream into packets. It watches incoming bytes for a start marker. After the marker it collects a length field and a type field, and then a CRC that covers only those two fields. The length is trusted only when that header CRC matches and the length is within a configured limit. Once the header is accepted, the block forwards each payload byte with the packet's type tag, and it marks the first and the last payload byte.

After the payload, a second CRC covers the payload bytes. When the packet closes, the block gives a one-cycle verdict: commit or abort. A downstream consumer holds any command effect until it sees the commit pulse. A byte that looks like a marker but is really stream data fails the header check within six more bytes. The receiver then goes back to hunting, so a false start never locks it into a long payload.

Top module: `pkt_hunt_rx`

## Requirements
- R1: After reset the block is hunting for a marker, and `pay_valid`, `pay_first`, `pay_last`, `end_ok` and `end_err` are all low.
- R2: While hunting, every accepted byte other than the marker value `SOP_BYTE` (default 0x55) is discarded and produces no output.
- R3: A packet on the wire is: marker, then length (2 bytes, high byte first), then type (2 bytes, high byte first), then header CRC (2 bytes), then `length` payload bytes, then payload CRC (2 bytes). Both CRCs use polynomial 0x1021 and start from 0xFFFF. Each is fed most significant bit first and sent high byte first. The header CRC covers the four length and type bytes, and the payload CRC covers the payload bytes. For an accepted header, each payload byte appears on `pay_data` with `pay_valid` high, on the clock edge that accepts it. While it is shown, `pay_type` carries the received type.
- R4: `pay_first` is high with the first payload byte and `pay_last` with the last one; both are high together for a one-byte payload. The cycle after `pay_last` carries no payload byte.
- R5: If the header CRC does not match, the packet is dropped without any output or end pulse. Hunting resumes with the byte that follows the second header CRC byte, and the header bytes already consumed are not scanned again for a marker.
- R6: A length greater than `MAX_LEN` is dropped exactly like a header CRC failure, even when its CRC is correct. A length equal to `MAX_LEN` is accepted.
- R7: On the edge that accepts the second payload CRC byte, the block pulses `end_ok` for one cycle if the CRC matches, or `end_err` if it does not. The two are never high together, and the block then hunts again.
- R8: A zero length is legal. No payload byte is produced, the payload CRC immediately follows the header CRC, and it is checked against 0xFFFF.
- R9: Cycles with `in_valid` low are ignored in every state, whatever `in_byte` holds, and the following cycle shows no payload byte and no end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Incoming stream byte |
| in_valid | input | 1 | `in_byte` holds a byte this cycle |
| pay_data | output | 8 | Payload byte |
| pay_valid | output | 1 | `pay_data` holds a payload byte |
| pay_type | output | 16 | Type tag of the packet being streamed |
| pay_first | output | 1 | First payload byte of the packet |
| pay_last | output | 1 | Last payload byte of the packet |
| end_ok | output | 1 | Packet closed with a good payload CRC (commit) |
| end_err | output | 1 | Packet closed with a bad payload CRC (abort) |

## Verification
The assertions assume that `in_byte` is meaningful only when `in_valid` is high. They also assume that the design is reset before any byte arrives, so the first cycle they look at is never a payload cycle. The stimulus drives only aligned whole packets, runs of noise without the marker, and gaps. During gaps `in_byte` deliberately holds the marker value, to show that an invalid byte can never start or disturb a packet. Rejected headers are followed either directly by a real marker or by marker-free noise, so the expected resume point is always clear.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

   localparam int BYTE_W  = 8;
   localparam int FIELD_W = 16;

   typedef enum logic [3:0] {
      ST_HUNT,
      ST_LEN_H,
      ST_LEN_L,
      ST_TYP_H,
      ST_TYP_L,
      ST_HCRC_H,
      ST_HCRC_L,
      ST_PAY,
      ST_PCRC_H,
      ST_PCRC_L
   } rx_state_e;

endpackage

// File: rtl/pkt_rx_crc.sv
module pkt_rx_crc #(
   parameter int             CW   = 16,
   parameter int             DW   = 8,
   parameter logic [CW-1:0]  POLY = 16'h1021,
   parameter logic [CW-1:0]  INIT = 16'hFFFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          upd,
   input  logic [DW-1:0] din,
   output logic [CW-1:0] crc
);

   localparam int PAD = CW - DW;

   initial begin
      assert (CW > DW) else $fatal(1, "crc width must exceed data width");
   end

   logic [CW-1:0] stage [0:DW];

   assign stage[0] = crc ^ {din, {PAD{1'b0}}};

   // one shift-and-xor per input bit, MSB first
   for (genvar k = 0; k < DW; k++) begin : g_bit
      assign stage[k+1] = stage[k][CW-1] ? ({stage[k][CW-2:0], 1'b0} ^ POLY)
                                         :  {stage[k][CW-2:0], 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   crc <= INIT;
      else if (clr) crc <= INIT;
      else if (upd) crc <= stage[DW];
   end

endmodule

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl
   import pkt_rx_pkg::*;
#(
   parameter logic [BYTE_W-1:0] SOP_BYTE = 8'h55,
   parameter int                MAX_LEN  = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [BYTE_W-1:0]   in_byte,
   input  logic                in_valid,
   input  logic [FIELD_W-1:0]  crc,
   output logic                crc_clr,
   output logic                crc_upd,
   output logic [BYTE_W-1:0]   pay_data,
   output logic                pay_valid,
   output logic [FIELD_W-1:0]  pay_type,
   output logic                pay_first,
   output logic                pay_last,
   output logic                end_ok,
   output logic                end_err
);

   localparam int LEN_CAP = (1 << FIELD_W) - 1;

   rx_state_e            state;
   logic [FIELD_W-1:0]   len_q;
   logic [FIELD_W-1:0]   typ_q;
   logic [FIELD_W-1:0]   left_q;
   logic [BYTE_W-1:0]    hi_q;
   logic                 len_ok;
   logic                 crc_match;

   // the length limit disappears when it covers the whole field
   if (MAX_LEN >= LEN_CAP) begin : g_len_any
      assign len_ok = 1'b1;
   end else begin : g_len_cap
      assign len_ok = (len_q <= FIELD_W'(MAX_LEN));
   end

   assign crc_match = ({hi_q, in_byte} == crc);
   assign pay_type  = typ_q;

   always_comb begin
      crc_clr = in_valid && (((state == ST_HUNT) && (in_byte == SOP_BYTE)) ||
                             (state == ST_HCRC_L));
      crc_upd = in_valid && ((state == ST_LEN_H) || (state == ST_LEN_L) ||
                             (state == ST_TYP_H) || (state == ST_TYP_L) ||
                             (state == ST_PAY));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_HUNT;
         len_q     <= '0;
         typ_q     <= '0;
         left_q    <= '0;
         hi_q      <= '0;
         pay_data  <= '0;
         pay_valid <= 1'b0;
         pay_first <= 1'b0;
         pay_last  <= 1'b0;
         end_ok    <= 1'b0;
         end_err   <= 1'b0;
      end else begin
         pay_valid <= 1'b0;
         pay_first <= 1'b0;
         pay_last  <= 1'b0;
         end_ok    <= 1'b0;
         end_err   <= 1'b0;
         if (in_valid) begin
            unique case (state)
               ST_HUNT:   if (in_byte == SOP_BYTE) state <= ST_LEN_H;
               ST_LEN_H:  begin len_q[15:8] <= in_byte; state <= ST_LEN_L;  end
               ST_LEN_L:  begin len_q[7:0]  <= in_byte; state <= ST_TYP_H;  end
               ST_TYP_H:  begin typ_q[15:8] <= in_byte; state <= ST_TYP_L;  end
               ST_TYP_L:  begin typ_q[7:0]  <= in_byte; state <= ST_HCRC_H; end
               ST_HCRC_H: begin hi_q        <= in_byte; state <= ST_HCRC_L; end
               ST_HCRC_L: begin
                  if (crc_match && len_ok) begin
                     left_q <= len_q;
                     state  <= (len_q == '0) ? ST_PCRC_H : ST_PAY;
                  end else begin
                     state  <= ST_HUNT;
                  end
               end
               ST_PAY: begin
                  pay_valid <= 1'b1;
                  pay_data  <= in_byte;
                  pay_first <= (left_q == len_q);
                  pay_last  <= (left_q == FIELD_W'(1));
                  left_q    <= left_q - FIELD_W'(1);
                  if (left_q == FIELD_W'(1)) state <= ST_PCRC_H;
               end
               ST_PCRC_H: begin hi_q <= in_byte; state <= ST_PCRC_L; end
               ST_PCRC_L: begin
                  end_ok  <= crc_match;
                  end_err <= !crc_match;
                  state   <= ST_HUNT;
               end
               default:   state <= ST_HUNT;
            endcase
         end
      end
   end

endmodule

// File: rtl/pkt_hunt_rx.sv
module pkt_hunt_rx
   import pkt_rx_pkg::*;
#(
   parameter logic [7:0]  SOP_BYTE = 8'h55,
   parameter int          MAX_LEN  = 64,
   parameter logic [15:0] CRC_POLY = 16'h1021,
   parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  in_byte,
   input  logic        in_valid,
   output logic [7:0]  pay_data,
   output logic        pay_valid,
   output logic [15:0] pay_type,
   output logic        pay_first,
   output logic        pay_last,
   output logic        end_ok,
   output logic        end_err
);

   initial begin
      assert (MAX_LEN >= 0 && MAX_LEN <= (1 << FIELD_W) - 1)
         else $fatal(1, "MAX_LEN outside the length field");
   end

   logic [FIELD_W-1:0] crc;
   logic               crc_clr;
   logic               crc_upd;

   pkt_rx_crc #(
      .CW   (FIELD_W),
      .DW   (BYTE_W),
      .POLY (CRC_POLY),
      .INIT (CRC_INIT)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .upd   (crc_upd),
      .din   (in_byte),
      .crc   (crc)
   );

   pkt_rx_ctrl #(
      .SOP_BYTE (SOP_BYTE),
      .MAX_LEN  (MAX_LEN)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_byte   (in_byte),
      .in_valid  (in_valid),
      .crc       (crc),
      .crc_clr   (crc_clr),
      .crc_upd   (crc_upd),
      .pay_data  (pay_data),
      .pay_valid (pay_valid),
      .pay_type  (pay_type),
      .pay_first (pay_first),
      .pay_last  (pay_last),
      .end_ok    (end_ok),
      .end_err   (end_err)
   );

endmodule

// File: rtl/pkt_hunt_rx_chk.sv
module pkt_hunt_rx_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [7:0]  in_byte,
   input logic        in_valid,
   input logic [7:0]  pay_data,
   input logic        pay_valid,
   input logic [15:0] pay_type,
   input logic        pay_first,
   input logic        pay_last,
   input logic        end_ok,
   input logic        end_err
);

   // R7
   end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(end_ok && end_err));

   // R4
   mark_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_first || pay_last) |-> pay_valid);

   // R4
   pay_end_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pay_last |=> !pay_valid);

   // R9
   gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!pay_valid && !end_ok && !end_err));

   // R3
   data_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid |-> (pay_data == $past(in_byte)));

   // R3
   type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_valid && !pay_last) |=> $stable(pay_type));

endmodule

bind pkt_hunt_rx pkt_hunt_rx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_byte   (in_byte),
   .in_valid  (in_valid),
   .pay_data  (pay_data),
   .pay_valid (pay_valid),
   .pay_type  (pay_type),
   .pay_first (pay_first),
   .pay_last  (pay_last),
   .end_ok    (end_ok),
   .end_err   (end_err)
);

// File: tb/pkt_hunt_rx_tb.sv
module pkt_hunt_rx_tb;

   localparam int MAXL = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        in_valid = 1'b0;
   logic [7:0]  pay_data;
   logic        pay_valid;
   logic [15:0] pay_type;
   logic        pay_first;
   logic        pay_last;
   logic        end_ok;
   logic        end_err;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pkt_hunt_rx #(.MAX_LEN(MAXL)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
      .pay_data(pay_data), .pay_valid(pay_valid), .pay_type(pay_type),
      .pay_first(pay_first), .pay_last(pay_last),
      .end_ok(end_ok), .end_err(end_err));

   // one cycle of stimulus and the outputs expected after its edge
   typedef struct packed {
      logic        v;
      logic [7:0]  b;
      logic        pv;
      logic [7:0]  pd;
      logic        pf;
      logic        pl;
      logic [15:0] pt;
      logic        eok;
      logic        eerr;
   } step_t;

   step_t steps[$];
   string tags[$];

   function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
      logic [15:0] r = c ^ {b, 8'h00};
      for (int i = 0; i < 8; i++)
         r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
      return r;
   endfunction

   function automatic logic [7:0] pay_byte(int seed, int i);
      if (i == 2) return 8'h55;
      return 8'((seed * 37 + i * 11 + 3) & 255);
   endfunction

   task automatic put(input logic v, input logic [7:0] b, input logic pv,
                      input logic pf, input logic pl, input logic [15:0] pt,
                      input logic eok, input logic eerr, input string tag);
      step_t s;
      s.v = v; s.b = b; s.pv = pv; s.pd = pv ? b : 8'h00;
      s.pf = pf; s.pl = pl; s.pt = pv ? pt : 16'h0000;
      s.eok = eok; s.eerr = eerr;
      steps.push_back(s);
      tags.push_back(tag);
   endtask

   task automatic put_plain(input logic [7:0] b, input string tag);
      put(1'b1, b, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, tag);
   endtask

   // invalid cycles carry the marker value on purpose
   task automatic put_gap(input int n);
      for (int i = 0; i < n; i++)
         put(1'b0, 8'h55, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, "R9");
   endtask

   task automatic put_noise(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b = 8'((seed + i * 29) & 255);
         if (b == 8'h55) b = 8'h54;
         put_plain(b, "R2");
      end
   endtask

   task automatic send_pkt(input int len, input logic [15:0] typ, input int seed,
                           input bit bad_h, input bit bad_p, input bit gaps,
                           input string tag);
      logic [15:0] hc = 16'hFFFF;
      logic [15:0] pc = 16'hFFFF;
      logic [7:0]  hb[4];
      logic [15:0] l16 = 16'(len);
      hb[0] = l16[15:8]; hb[1] = l16[7:0]; hb[2] = typ[15:8]; hb[3] = typ[7:0];
      for (int i = 0; i < 4; i++) hc = crc_step(hc, hb[i]);
      if (bad_h) hc = hc ^ 16'h0100;
      put_plain(8'h55, tag);
      for (int i = 0; i < 4; i++) put_plain(hb[i], tag);
      put_plain(hc[15:8], tag);
      put_plain(hc[7:0], tag);
      if (bad_h || len > MAXL) return;
      for (int i = 0; i < len; i++) begin
         logic [7:0] b = pay_byte(seed, i);
         pc = crc_step(pc, b);
         put(1'b1, b, 1'b1, i == 0, i == len - 1, typ, 1'b0, 1'b0, tag);
         if (gaps && (i % 2 == 0)) put_gap(1);
      end
      if (bad_p) pc = pc ^ 16'h8000;
      put_plain(pc[15:8], tag);
      put(1'b1, pc[7:0], 1'b0, 1'b0, 1'b0, 16'h0, !bad_p, bad_p, tag);
   endtask

   task automatic compare(input int i);
      step_t e = steps[i];
      logic [28:0] act, exp;
      act = {pay_valid, pay_first, pay_last, end_ok, end_err,
             e.pv ? pay_data : 8'h00, e.pv ? pay_type : 16'h0000};
      exp = {e.pv, e.pf, e.pl, e.eok, e.eerr, e.pd, e.pt};
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s step %0d actual=%h expected=%h", tags[i], i, act, exp);
      end
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog all requirements actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // build the stimulus and its expected outputs
      put_gap(3);
      put_noise(12, 7);                                    // R2
      send_pkt(5, 16'h1234, 1, 0, 0, 0, "R3");             // R3
      send_pkt(8, 16'hBEEF, 2, 0, 0, 1, "R9");             // R9 gaps inside payload
      send_pkt(1, 16'hABCD, 3, 0, 0, 0, "R4");             // R4 first and last together
      send_pkt(4, 16'h0101, 4, 0, 1, 0, "R7");             // R7 abort
      send_pkt(6, 16'h0202, 5, 0, 0, 0, "R7");             // R7 commit
      send_pkt(0, 16'h0A0A, 6, 0, 0, 0, "R8");             // R8 empty, good
      send_pkt(0, 16'h0B0B, 6, 0, 1, 0, "R8");             // R8 empty, bad
      send_pkt(3, 16'h5555, 7, 1, 0, 0, "R5");             // R5 false marker
      send_pkt(3, 16'h0303, 8, 0, 0, 0, "R5");             // R5 resync at next byte
      send_pkt(3, 16'h5555, 9, 1, 0, 0, "R5");             // R5 no rescan
      put_noise(5, 40);
      send_pkt(2, 16'h0404, 10, 0, 0, 0, "R5");
      send_pkt(MAXL + 1, 16'h0505, 11, 0, 0, 0, "R6");     // R6 too long
      send_pkt(MAXL, 16'h0606, 12, 0, 0, 0, "R6");         // R6 boundary
      put_gap(2);

      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;                                            // R1
      if ({pay_valid, pay_first, pay_last, end_ok, end_err} !== 5'b0) begin
         failures++;
         $display("FAIL R1 reset actual=%b expected=00000",
                  {pay_valid, pay_first, pay_last, end_ok, end_err});
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;                                            // R1
      if ({pay_valid, pay_first, pay_last, end_ok, end_err} !== 5'b0) begin
         failures++;
         $display("FAIL R1 after release actual=%b expected=00000",
                  {pay_valid, pay_first, pay_last, end_ok, end_err});
      end

      for (int i = 0; i < steps.size(); i++) begin
         if (i > 0) compare(i - 1);
         in_valid = steps[i].v;
         in_byte  = steps[i].b;
         @(negedge clk);
      end
      compare(steps.size() - 1);
      in_valid = 1'b0;
      in_byte  = 8'h00;
      @(negedge clk);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule